// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Register Front End

This block is the digital side of a two-channel, parallel-input, current-steering converter. A host presents a data word on a parallel bus together with an active-low write strobe, an active-high load strobe and a two-bit channel address. Each channel keeps two registers: a staging register and an output register. The output register holds the code that drives the switches. Because of the two stages, the host can stage new codes in both channels and then apply them in the same cycle.

Strobes, address and data are re-timed onto the system clock through a two-flop synchronizer. The register action that a strobe combination selects is applied on every clock cycle in which that combination is present. An asynchronous, active-low clear input overrides every other control. It sets both channels to zero scale or to midscale, as chosen by a level-select pin. Each output code is split into two parts. The top four bits become fifteen equally weighted segment enables in thermometer form. The remaining low bits drive the binary ladder switches directly. A one-cycle update flag per channel marks each cycle in which that channel's output code changes. A build parameter selects a 14-bit variant with a shorter ladder.

Top module: `dual_dac_front`

## Requirements
- R1: The synchronized address selects the channels: 2'b00 selects channel A only, 2'b11 selects channel B only, 2'b10 selects both, and 2'b01 selects neither, so no register changes.
- R2: With write low and load low, each selected channel copies the data bus into its staging register and keeps its output code.
- R3: With write high and load high, each selected channel copies its staging register into its output code. The data bus has no effect.
- R4: With write low and load high, both stages of each selected channel take the data bus, so the bus appears on the output code.
- R5: With write high and load low, no register in either channel changes. A later load therefore still applies the previously staged value.
- R6: Clear sets the staging and output registers of both channels to 0 when the level select is 0, and to 1 << (DATA_W-1) (0x8000 at 16 bits) when the level select is 1.
- R7: Clear acts asynchronously, before any clock edge. While clear is held low, all strobe combinations are ignored.
- R8: Segment output bit i (i = 0..14) is 1 exactly when the top four bits of the output code, read as an unsigned number, are greater than i. The enabled segments therefore fill from bit 0 upward.
- R9: The binary output equals the output code with its top four bits removed (bits DATA_W-5 down to 0).
- R10: A strobe combination reaches the output registers on the third rising clock edge after it is applied. For a write-then-load pulse, the staging write happens during the low phase, and the output changes on the third edge after both strobes go high.
- R11: A channel's update flag is high for exactly one cycle, the cycle in which its new output code is first visible. A load that addresses both channels raises both flags in the same cycle.
- R12: With DATA_W = 14, the midscale clear value is 0x2000, the binary output has 10 bits, and the segments decode code bits 13..10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| clr_n | input | 1 | Asynchronous active-low clear of both channels |
| mid_sel | input | 1 | Clear level: 0 gives zero scale, 1 gives midscale |
| data_i | input | DATA_W | Parallel data bus |
| wr_n | input | 1 | Write strobe, active low |
| ld | input | 1 | Load strobe, active high |
| addr | input | 2 | Channel address |
| code_a_o | output | DATA_W | Channel A output code |
| code_b_o | output | DATA_W | Channel B output code |
| seg_a_o | output | 15 | Channel A thermometer segment enables |
| seg_b_o | output | 15 | Channel B thermometer segment enables |
| bin_a_o | output | DATA_W-4 | Channel A binary ladder switches |
| bin_b_o | output | DATA_W-4 | Channel B binary ladder switches |
| upd_a_o | output | 1 | Channel A one-cycle update flag |
| upd_b_o | output | 1 | Channel B one-cycle update flag |

## Verification
The assertions assume that data, strobes and address change together and stay stable long enough for the synchronizer to pass them on as one coherent word. The stimulus meets this by changing every control input on the same falling edge and holding it for at least three cycles. The assertions also assume that clear is never released in the same cycle as a strobe combination that changes a register. The stimulus returns the strobes to the idle combination (write high, load low) and waits before it raises clear. The level select is changed only while no clear or reset is active, so the clear value seen by the checks is well defined.

// File: rtl/dac_fe_pkg.sv
// Shared types and decode helpers for the dual-channel converter front end.
// Assumes: a two-bit address and a write/load strobe pair as its only control inputs.
package dac_fe_pkg;

    // Channel address codes; bit pattern is part of the external contract.
    typedef enum logic [1:0] {
        SEL_A    = 2'b00,
        SEL_NONE = 2'b01,
        SEL_BOTH = 2'b10,
        SEL_B    = 2'b11
    } chan_sel_e;

    // Register action chosen by the strobe pair.
    typedef enum logic [1:0] {
        OP_HOLD,
        OP_WRITE,
        OP_LOAD,
        OP_THRU
    } reg_op_e;

    // Map write (active low) and load (active high) to a register action.
    function automatic reg_op_e op_from_strobes(input logic wr_n, input logic ld);
        reg_op_e op;
        case ({wr_n, ld})
            2'b00:   op = OP_WRITE;
            2'b11:   op = OP_LOAD;
            2'b01:   op = OP_THRU;
            default: op = OP_HOLD;
        endcase
        return op;
    endfunction

    // True when the address selects the given channel (is_b = 0 for A).
    function automatic logic chan_hit(input chan_sel_e sel, input logic is_b);
        logic hit;
        case (sel)
            SEL_A:    hit = !is_b;
            SEL_B:    hit = is_b;
            SEL_BOTH: hit = 1'b1;
            default:  hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/dac_fe_sync.sv
// Two-flop synchronizer for a bundle of related control bits.
// Assumes: the bundle is stable for several clocks so that all bits resolve together.
module dac_fe_sync #(
    parameter int              W       = 8,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Capture then re-capture the asynchronous bundle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= RST_VAL;
            stage2_q <= RST_VAL;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;

endmodule

// File: rtl/dac_fe_chan.sv
// One converter channel: staging register, output register and update flag.
// Assumes: hit/op/data come from the synchronizer and are aligned to one another.
// Clear is asynchronous and wins over system reset and every register action.
module dac_fe_chan
    import dac_fe_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              mid_sel,
    input  logic              hit,
    input  reg_op_e           op,
    input  logic [DATA_W-1:0] data,
    output logic [DATA_W-1:0] code_o,
    output logic              upd_o
);

    localparam logic [DATA_W-1:0] ZERO_CODE = '0;
    localparam logic [DATA_W-1:0] MID_CODE  = {1'b1, {(DATA_W-1){1'b0}}};

    logic [DATA_W-1:0] in_q, in_d;
    logic [DATA_W-1:0] code_q, code_d;
    logic [DATA_W-1:0] clr_val;
    logic              upd_q;

    // Level selected for clear and system reset.
    assign clr_val = mid_sel ? MID_CODE : ZERO_CODE;

    // Next state of both stages from the selected register action.
    always_comb begin
        in_d   = in_q;
        code_d = code_q;
        if (hit) begin
            case (op)
                OP_WRITE: in_d = data;
                OP_LOAD:  code_d = in_q;
                OP_THRU: begin
                    in_d   = data;
                    code_d = data;
                end
                default: ;
            endcase
        end
    end

    // State update: asynchronous clear, synchronous reset, then the action.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            in_q   <= clr_val;
            code_q <= clr_val;
            upd_q  <= 1'b0;
        end else if (!rst_n) begin
            in_q   <= clr_val;
            code_q <= clr_val;
            upd_q  <= 1'b0;
        end else begin
            in_q   <= in_d;
            code_q <= code_d;
            upd_q  <= (code_d != code_q);
        end
    end

    assign code_o = code_q;
    assign upd_o  = upd_q;

    // Writing stages the bus and leaves the output alone.
    assert_write_stages_R2: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (hit && op == OP_WRITE) |=> ($stable(code_q) && in_q == $past(data)));

    // Loading moves the staged value to the output.
    assert_load_copies_R3: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (hit && op == OP_LOAD) |=> (code_q == $past(in_q)));

    // Transparent action passes the bus to both stages.
    assert_thru_passes_R4: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (hit && op == OP_THRU) |=> (code_q == $past(data) && in_q == $past(data)));

    // Idle strobes or a miss leave both stages untouched.
    assert_idle_holds_R5: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (!hit || op == OP_HOLD) |=> ($stable(code_q) && $stable(in_q)));

    // The flag only rises in a cycle whose code differs from the previous one.
    assert_flag_on_change_R11: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        upd_q |-> (code_q != $past(code_q)));

endmodule

// File: rtl/dac_fe_seg.sv
// Splits an output code into thermometer segment enables and binary ladder bits.
// Assumes: TOP_W top bits go to 2**TOP_W-1 equally weighted segments.
module dac_fe_seg #(
    parameter int DATA_W = 16,
    parameter int TOP_W  = 4,
    localparam int SEG_N = (1 << TOP_W) - 1,
    localparam int LOW_W = DATA_W - TOP_W
) (
    input  logic [DATA_W-1:0] code_i,
    output logic [SEG_N-1:0]  seg_o,
    output logic [LOW_W-1:0]  bin_o
);

    logic [TOP_W-1:0] top_bits;

    assign top_bits = code_i[DATA_W-1 -: TOP_W];
    assign bin_o    = code_i[LOW_W-1:0];

    // One comparator per segment: enabled when the top value exceeds its index.
    for (genvar g = 0; g < SEG_N; g++) begin : g_seg
        assign seg_o[g] = ({1'b0, top_bits} > (TOP_W + 1)'(g));
    end

    // Enabled segments are contiguous from bit 0 and count equals the top value.
    always_comb begin
        assert_thermo_shape_R8: assert (((seg_o & (seg_o + 1'b1)) == '0)
                                        && ($countones(seg_o) == int'(top_bits)));
    end

endmodule

// File: rtl/dual_dac_front.sv
// Two-channel double-buffered register front end of a parallel-input converter.
// Assumes: controls are asynchronous to clk and held for at least three clocks;
// clear is released only while the strobes are idle.
module dual_dac_front
    import dac_fe_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int TOP_W  = 4,
    localparam int SEG_N  = (1 << TOP_W) - 1,
    localparam int LOW_W  = DATA_W - TOP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              mid_sel,
    input  logic [DATA_W-1:0] data_i,
    input  logic              wr_n,
    input  logic              ld,
    input  logic [1:0]        addr,
    output logic [DATA_W-1:0] code_a_o,
    output logic [DATA_W-1:0] code_b_o,
    output logic [SEG_N-1:0]  seg_a_o,
    output logic [SEG_N-1:0]  seg_b_o,
    output logic [LOW_W-1:0]  bin_a_o,
    output logic [LOW_W-1:0]  bin_b_o,
    output logic              upd_a_o,
    output logic              upd_b_o
);

    localparam int               N_CH    = 2;
    localparam int               CTRL_W  = DATA_W + 4;
    localparam logic [CTRL_W-1:0] CTRL_IDLE = {{DATA_W{1'b0}}, 1'b1, 1'b0, SEL_NONE};

    logic [CTRL_W-1:0] ctrl_raw, ctrl_sync;
    logic [DATA_W-1:0] s_data;
    logic              s_wr_n, s_ld;
    chan_sel_e         s_addr;
    reg_op_e           s_op;

    logic [DATA_W-1:0] code [N_CH];
    logic [SEG_N-1:0]  seg  [N_CH];
    logic [LOW_W-1:0]  bin  [N_CH];
    logic [N_CH-1:0]   upd;

    // Bundle all controls so they cross into the clock domain together.
    assign ctrl_raw = {data_i, wr_n, ld, addr};

    dac_fe_sync #(
        .W       (CTRL_W),
        .RST_VAL (CTRL_IDLE)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ctrl_raw),
        .sync_o  (ctrl_sync)
    );

    assign s_data = ctrl_sync[CTRL_W-1:4];
    assign s_wr_n = ctrl_sync[3];
    assign s_ld   = ctrl_sync[2];
    assign s_addr = chan_sel_e'(ctrl_sync[1:0]);
    assign s_op   = op_from_strobes(s_wr_n, s_ld);

    // One register pair and one switch decoder per channel.
    for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
        logic hit;
        assign hit = chan_hit(s_addr, ch == 1);

        dac_fe_chan #(
            .DATA_W (DATA_W)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr_n   (clr_n),
            .mid_sel (mid_sel),
            .hit     (hit),
            .op      (s_op),
            .data    (s_data),
            .code_o  (code[ch]),
            .upd_o   (upd[ch])
        );

        dac_fe_seg #(
            .DATA_W (DATA_W),
            .TOP_W  (TOP_W)
        ) u_seg (
            .code_i (code[ch]),
            .seg_o  (seg[ch]),
            .bin_o  (bin[ch])
        );
    end

    assign code_a_o = code[0];
    assign code_b_o = code[1];
    assign seg_a_o  = seg[0];
    assign seg_b_o  = seg[1];
    assign bin_a_o  = bin[0];
    assign bin_b_o  = bin[1];
    assign upd_a_o  = upd[0];
    assign upd_b_o  = upd[1];

    // The no-channel address never moves either output.
    assert_none_addr_holds_R1: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (s_addr == SEL_NONE) |=> ($stable(code[0]) && $stable(code[1])));

    // A load to both channels raises both update flags together.
    assert_both_flags_together_R11: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (s_addr == SEL_BOTH && s_op != OP_HOLD) |=> (upd[0] == (code[0] != $past(code[0])))
                                                  && (upd[1] == (code[1] != $past(code[1]))));

endmodule

// File: tb/test_dual_dac_front.sv
// Directed bench: one task per scenario, each checking its own results.
module test_dual_dac_front;

    localparam logic [1:0] A_ONLY = 2'b00;
    localparam logic [1:0] NONE   = 2'b01;
    localparam logic [1:0] BOTH   = 2'b10;
    localparam logic [1:0] B_ONLY = 2'b11;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, clr_n, mid_sel, wr_n, ld;
    logic [1:0]  addr;
    logic [15:0] data;

    logic [15:0] code_a, code_b;
    logic [14:0] seg_a, seg_b;
    logic [11:0] bin_a, bin_b;
    logic        upd_a, upd_b;

    logic [13:0] n_code_a, n_code_b;
    logic [14:0] n_seg_a, n_seg_b;
    logic [9:0]  n_bin_a, n_bin_b;
    logic        n_upd_a, n_upd_b;

    dual_dac_front i_dual_dac_front (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .mid_sel(mid_sel),
        .data_i(data), .wr_n(wr_n), .ld(ld), .addr(addr),
        .code_a_o(code_a), .code_b_o(code_b), .seg_a_o(seg_a), .seg_b_o(seg_b),
        .bin_a_o(bin_a), .bin_b_o(bin_b), .upd_a_o(upd_a), .upd_b_o(upd_b)
    );

    dual_dac_front #(.DATA_W(14)) i_dual_dac_front_n14 (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .mid_sel(mid_sel),
        .data_i(data[13:0]), .wr_n(wr_n), .ld(ld), .addr(addr),
        .code_a_o(n_code_a), .code_b_o(n_code_b), .seg_a_o(n_seg_a), .seg_b_o(n_seg_b),
        .bin_a_o(n_bin_a), .bin_b_o(n_bin_b), .upd_a_o(n_upd_a), .upd_b_o(n_upd_b)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    bit mon_en = 1'b0;
    int cnt_a = 0, cnt_b = 0, mism = 0;

    // Count update pulses and misaligned flags while enabled.
    always @(negedge clk) begin
        if (mon_en) begin
            if (upd_a) cnt_a++;
            if (upd_b) cnt_b++;
            if (upd_a != upd_b) mism++;
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
        end
    endtask

    task automatic drive(input logic [15:0] d, input logic w, input logic l,
                         input logic [1:0] a, input int n);
        @(negedge clk);
        data = d; wr_n = w; ld = l; addr = a;
        repeat (n) @(negedge clk);
    endtask

    task automatic settle();
        drive(16'h0000, 1'b1, 1'b0, NONE, 4);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; clr_n = 1'b1; mid_sel = 1'b0;
        data = '0; wr_n = 1'b1; ld = 1'b0; addr = NONE;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        settle();
        chk("R6 reset code A", code_a, 32'h0);
        chk("R6 reset code B", code_b, 32'h0);
        chk("R8 reset segments A", seg_a, 32'h0);
        chk("R11 reset flags", {upd_a, upd_b}, 32'h0);
        chk("R12 reset narrow code", n_code_a, 32'h0);
    endtask

    task automatic t_clear_mid();
        mid_sel = 1'b1;
        @(negedge clk); #2 clr_n = 1'b0;
        @(negedge clk); clr_n = 1'b1;
        settle();
        chk("R6 mid clear code A", code_a, 32'h8000);
        chk("R6 mid clear code B", code_b, 32'h8000);
        chk("R8 mid segments A", seg_a, 32'h00FF);
        chk("R9 mid binary A", bin_a, 32'h0);
        chk("R12 narrow mid code", n_code_b, 32'h2000);
        chk("R12 narrow mid segments", n_seg_b, 32'h00FF);
    endtask

    task automatic t_write_then_load();
        drive(16'h1234, 1'b0, 1'b0, A_ONLY, 4);
        settle();
        chk("R2 write holds output A", code_a, 32'h8000);
        chk("R2 write leaves B", code_b, 32'h8000);
        drive(16'hDEAD, 1'b1, 1'b1, A_ONLY, 4);
        settle();
        chk("R3 load copies staged A", code_a, 32'h1234);
        chk("R3 load leaves B", code_b, 32'h8000);
        chk("R12 narrow load code", n_code_a, 32'h1234);
        chk("R12 narrow segments", n_seg_a, 32'h000F);
        chk("R12 narrow binary", n_bin_a, 32'h0234);
    endtask

    task automatic t_address_map();
        drive(16'h5555, 1'b0, 1'b1, NONE, 4);
        settle();
        chk("R1 none address A", code_a, 32'h1234);
        chk("R1 none address B", code_b, 32'h8000);
        drive(16'h4321, 1'b0, 1'b1, B_ONLY, 4);
        settle();
        chk("R1 B address leaves A", code_a, 32'h1234);
        chk("R4 transparent B", code_b, 32'h4321);
    endtask

    task automatic t_both_update();
        drive(16'hA5C3, 1'b0, 1'b0, BOTH, 4);
        settle();
        mon_en = 1'b1;
        drive(16'h0000, 1'b1, 1'b1, BOTH, 4);
        settle();
        mon_en = 1'b0;
        chk("R1 both code A", code_a, 32'hA5C3);
        chk("R1 both code B", code_b, 32'hA5C3);
        chk("R11 flag A pulses", cnt_a, 32'd1);
        chk("R11 flag B pulses", cnt_b, 32'd1);
        chk("R11 flags misaligned", mism, 32'd0);
        chk("R8 segments A5C3", seg_a, 32'h03FF);
        chk("R9 binary A5C3", bin_b, 32'h05C3);
    endtask

    task automatic t_idle_ignored();
        drive(16'hFFFF, 1'b1, 1'b0, BOTH, 4);
        settle();
        chk("R5 idle code A", code_a, 32'hA5C3);
        drive(16'h0000, 1'b1, 1'b1, BOTH, 4);
        settle();
        chk("R5 staged A untouched", code_a, 32'hA5C3);
        chk("R5 staged B untouched", code_b, 32'hA5C3);
    endtask

    task automatic t_transparent_full();
        drive(16'hF000, 1'b0, 1'b1, A_ONLY, 4);
        settle();
        chk("R4 transparent A", code_a, 32'hF000);
        chk("R8 all segments", seg_a, 32'h7FFF);
        chk("R9 binary zero", bin_a, 32'h0);
        chk("R4 B unchanged", code_b, 32'hA5C3);
    endtask

    task automatic t_pulse_latency();
        drive(16'h0FFF, 1'b0, 1'b0, B_ONLY, 3);
        chk("R10 low phase holds B", code_b, 32'hA5C3);
        wr_n = 1'b1; ld = 1'b1;
        @(negedge clk);
        chk("R10 edge 1 old", code_b, 32'hA5C3);
        @(negedge clk);
        chk("R10 edge 2 old", code_b, 32'hA5C3);
        @(negedge clk);
        chk("R10 edge 3 new", code_b, 32'h0FFF);
        chk("R8 no segments", seg_b, 32'h0);
        chk("R9 binary FFF", bin_b, 32'h0FFF);
        settle();
    endtask

    task automatic t_async_clear();
        mid_sel = 1'b0;
        @(negedge clk); #2 clr_n = 1'b0;
        #1;
        chk("R7 clear before edge A", code_a, 32'h0);
        chk("R7 clear before edge B", code_b, 32'h0);
        drive(16'h7777, 1'b0, 1'b1, BOTH, 4);
        chk("R7 strobes ignored A", code_a, 32'h0);
        chk("R7 strobes ignored B", code_b, 32'h0);
        settle();
        clr_n = 1'b1;
        settle();
        chk("R6 zero clear A", code_a, 32'h0);
        chk("R6 zero clear narrow", n_code_b, 32'h0);
    endtask

    initial begin
        t_reset();
        t_clear_mid();
        t_write_then_load();
        t_address_map();
        t_both_update();
        t_idle_ignored();
        t_transparent_full();
        t_pulse_latency();
        t_async_clear();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule